// File: doc/BRIEF.md
# Character LCD Start-up Sequencer

This block drives a character display controller through its start-up routine. After a power-on wait it hands out one step at a time on a command port: the bus-width setup, display and cursor enable, and entry mode. It then writes a message split across two lines and finishes with a short shift-and-home tail. A separate bus interface performs the enable-strobe timing and the busy polling for each step. It answers with a single-cycle acknowledge once the step is complete. The sequencer holds a step until that acknowledge arrives.

The width input selects an 8-bit or 4-bit data bus. In 4-bit mode the display controller still expects 8-bit transfers at first. The sequencer therefore marks its first step as a lone upper nibble, and every step after it is a full byte that the bus interface splits into two nibbles. The message is a parameter of packed bytes. A split parameter says how many characters go on line one before the cursor jumps to line two.

A done flag rises after the last step is acknowledged. An error flag records an acknowledge that arrived when no step was pending. A start pulse abandons whatever is in flight and runs the whole sequence again from the power-on wait.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset release, or after the cycle in which start_i is high, req_o stays low for exactly POR_CYCLES clock cycles and then presents step 0.
- R2: With mode4_i low, the first step is a command (rs_o=0, nibble_o=0) with data 0x38.
- R3: With mode4_i high, the first step has nibble_o=1, rs_o=0 and data 0x20, so the upper nibble is 0010. The step after it is command 0x28 with nibble_o=0.
- R4: After the function-set command come command 0x0E (display and cursor on, blink off) and then command 0x06 (increment, no display shift).
- R5: Characters 0..SPLIT-1 follow as data steps (rs_o=1) in order, then command 0xC0, then characters SPLIT..MSG_LEN-1 as data steps. Character k is MSG bits [8k+7:8k].
- R6: With TAIL_EN set, the last three steps are command 0x07, a data step carrying TAIL_CHAR, and command 0x02.
- R7: While req_o is high and ack_i is low, req_o, rs_o, nibble_o and data_o hold their values. The sequence advances by exactly one step per acknowledge.
- R8: The cycle after the last step is acknowledged, done_o is high and req_o is low. Both hold until start_i.
- R9: A start pulse in any state restarts from the power-on wait. In the next cycle req_o, done_o and err_o are all low.
- R10: ack_i high while req_o is low sets err_o. err_o stays set until start_i or reset, and the sequence does not advance.
- R11: mode4_i is sampled only during the power-on wait. Changes while steps are being issued have no effect on the steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the full sequence |
| mode4_i | input | 1 | 1 selects a 4-bit data bus, 0 selects an 8-bit bus |
| ack_i | input | 1 | Bus interface has completed the pending step |
| req_o | output | 1 | A step is pending |
| rs_o | output | 1 | Register select of the step: 0 command, 1 data |
| nibble_o | output | 1 | Send only the upper nibble, in a single transfer |
| data_o | output | 8 | Step byte |
| done_o | output | 1 | Sequence finished |
| err_o | output | 1 | Acknowledge received with no step pending |

## Verification
The hardest situation to reach is a width-select change after the power-on wait has ended. Only the latched value should shape the steps, but the change leaves no direct mark at the ports. The bench flips mode4_i right after the first step appears and checks the whole remaining step list against the mode chosen at start. Acknowledge latency is drawn at random for each step, and the hold of each step is checked on every wait cycle. Other directed cases are a restart in the middle of a sequence and a stray acknowledge after completion.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef struct packed {
    logic       nib;
    logic       rs;
    logic [7:0] data;
  } lcd_step_t;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  localparam logic [7:0] CMD_FS8         = 8'h38;
  localparam logic [7:0] CMD_FS4         = 8'h28;
  localparam logic [7:0] NIB_FS          = 8'h20;
  localparam logic [7:0] CMD_DISP_ON     = 8'h0E;
  localparam logic [7:0] CMD_ENTRY_INC   = 8'h06;
  localparam logic [7:0] CMD_ENTRY_SHIFT = 8'h07;
  localparam logic [7:0] CMD_LINE2       = 8'hC0;
  localparam logic [7:0] CMD_HOME        = 8'h02;

endpackage

// File: rtl/lcd_por_timer.sv
module lcd_por_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/lcd_step_table.sv
module lcd_step_table
  import lcd_init_pkg::*;
#(
  parameter int                    MSG_LEN   = 6,
  parameter int                    SPLIT     = 3,
  parameter logic [8*MSG_LEN-1:0]  MSG       = '0,
  parameter bit                    TAIL_EN   = 1'b1,
  parameter logic [7:0]            TAIL_CHAR = 8'h2A,
  parameter int                    IW        = 4
) (
  input  logic [IW-1:0] idx_i,
  input  logic          mode4_i,
  output lcd_step_t     step_o,
  output logic          last_o
);
  localparam int TAIL_N   = TAIL_EN ? 3 : 0;
  localparam int BODY_N   = 4 + MSG_LEN + TAIL_N;
  localparam int LINE2_AT = 3 + SPLIT;
  localparam int TAIL_BEG = 4 + MSG_LEN;

  int        rel;
  lcd_step_t tail_step;

  always_comb rel = int'(idx_i) - (mode4_i ? 1 : 0);

  generate
    if (TAIL_EN) begin : g_tail
      always_comb begin
        case (rel - TAIL_BEG)
          0:       tail_step = '{nib: 1'b0, rs: 1'b0, data: CMD_ENTRY_SHIFT};
          1:       tail_step = '{nib: 1'b0, rs: 1'b1, data: TAIL_CHAR};
          default: tail_step = '{nib: 1'b0, rs: 1'b0, data: CMD_HOME};
        endcase
      end
    end else begin : g_no_tail
      assign tail_step = '0;
    end
  endgenerate

  always_comb begin
    step_o = '0;
    if (mode4_i && idx_i == '0) begin
      step_o = '{nib: 1'b1, rs: 1'b0, data: NIB_FS};
    end else if (rel == 0) begin
      step_o.data = mode4_i ? CMD_FS4 : CMD_FS8;
    end else if (rel == 1) begin
      step_o.data = CMD_DISP_ON;
    end else if (rel == 2) begin
      step_o.data = CMD_ENTRY_INC;
    end else if (rel < LINE2_AT) begin
      step_o.rs   = 1'b1;
      step_o.data = MSG[8*(rel-3) +: 8];
    end else if (rel == LINE2_AT) begin
      step_o.data = CMD_LINE2;
    end else if (rel < TAIL_BEG) begin
      step_o.rs   = 1'b1;
      step_o.data = MSG[8*(rel-4) +: 8];
    end else begin
      step_o = tail_step;
    end
  end

  assign last_o = (rel == BODY_N - 1);
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_init_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode4_i,
  input  logic          ack_i,
  input  logic          expire_i,
  input  logic          last_i,
  output logic          wait_o,
  output logic          req_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mode_o,
  output logic [IW-1:0] idx_o
);
  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic          mode_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      idx_q   <= '0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_WAIT;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ack_i && state_q != ST_ISSUE) err_q <= 1'b1;
      case (state_q)
        ST_WAIT: begin
          mode_q <= mode4_i;
          idx_q  <= '0;
          if (expire_i) state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (ack_i) begin
            if (last_i) state_q <= ST_DONE;
            else        idx_q   <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign wait_o = (state_q == ST_WAIT);
  assign req_o  = (state_q == ST_ISSUE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;
  assign mode_o = mode_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int                   POR_CYCLES = 20,
  parameter int                   MSG_LEN    = 6,
  parameter int                   SPLIT      = 3,
  parameter logic [8*MSG_LEN-1:0] MSG        = 48'h214F4C4C4548,
  parameter bit                   TAIL_EN    = 1'b1,
  parameter logic [7:0]           TAIL_CHAR  = 8'h2A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       mode4_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic       rs_o,
  output logic       nibble_o,
  output logic [7:0] data_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int N_MAX = 1 + 4 + MSG_LEN + 3;
  localparam int IW    = $clog2(N_MAX + 1);

  logic          wait_s, expire_s, last_s, mode_s, req_s;
  logic [IW-1:0] idx_s;
  lcd_step_t     step_s;

  lcd_por_timer #(.CYCLES(POR_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wait_s),
    .clr_i    (start_i),
    .expire_o (expire_s)
  );

  lcd_seq_ctrl #(.IW(IW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode4_i  (mode4_i),
    .ack_i    (ack_i),
    .expire_i (expire_s),
    .last_i   (last_s),
    .wait_o   (wait_s),
    .req_o    (req_s),
    .done_o   (done_o),
    .err_o    (err_o),
    .mode_o   (mode_s),
    .idx_o    (idx_s)
  );

  lcd_step_table #(
    .MSG_LEN   (MSG_LEN),
    .SPLIT     (SPLIT),
    .MSG       (MSG),
    .TAIL_EN   (TAIL_EN),
    .TAIL_CHAR (TAIL_CHAR),
    .IW        (IW)
  ) u_table (
    .idx_i   (idx_s),
    .mode4_i (mode_s),
    .step_o  (step_s),
    .last_o  (last_s)
  );

  assign req_o    = req_s;
  assign rs_o     = req_s & step_s.rs;
  assign nibble_o = req_s & step_s.nib;
  assign data_o   = req_s ? step_s.data : 8'h00;
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ack_i,
  input logic       req_o,
  input logic       rs_o,
  input logic       nibble_o,
  input logic [7:0] data_o,
  input logic       done_o,
  input logic       err_o
);
  p_step_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !start_i) |=> (req_o && $stable(data_o) && $stable(rs_o) && $stable(nibble_o)));

  p_done_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && req_o));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_nibble_form_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nibble_o |-> (req_o && !rs_o && data_o == 8'h20));

  p_restart_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!req_o && !done_o && !err_o));

  p_stray_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && !start_i) |=> err_o);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .ack_i    (ack_i),
  .req_o    (req_o),
  .rs_o     (rs_o),
  .nibble_o (nibble_o),
  .data_o   (data_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;
  localparam int                 POR       = 20;
  localparam int                 MLEN      = 6;
  localparam int                 SPL       = 3;
  localparam logic [8*MLEN-1:0]  MSGV      = 48'h214F4C4C4548;
  localparam logic [7:0]         TCHAR     = 8'h2A;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       mode4_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       req_o, rs_o, nibble_o, done_o, err_o;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  lcd_init_seq #(
    .POR_CYCLES(POR), .MSG_LEN(MLEN), .SPLIT(SPL), .MSG(MSGV),
    .TAIL_EN(1'b1), .TAIL_CHAR(TCHAR)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode4_i(mode4_i),
    .ack_i(ack_i), .req_o(req_o), .rs_o(rs_o), .nibble_o(nibble_o),
    .data_o(data_o), .done_o(done_o), .err_o(err_o)
  );

  // {nibble, rs, data}
  function automatic logic [9:0] exp_step(input bit m4, input int i);
    int r;
    r = i - (m4 ? 1 : 0);
    if (m4 && i == 0) return {2'b10, 8'h20};
    if (r == 0) return {2'b00, m4 ? 8'h28 : 8'h38};
    if (r == 1) return {2'b00, 8'h0E};
    if (r == 2) return {2'b00, 8'h06};
    if (r < 3 + SPL) return {2'b01, MSGV[8*(r-3) +: 8]};
    if (r == 3 + SPL) return {2'b00, 8'hC0};
    if (r < 4 + MLEN) return {2'b01, MSGV[8*(r-4) +: 8]};
    if (r == 4 + MLEN) return {2'b00, 8'h07};
    if (r == 5 + MLEN) return {2'b01, TCHAR};
    return {2'b00, 8'h02};
  endfunction

  function automatic string tag_of(input bit m4, input int i, input bit flip);
    int r;
    r = i - (m4 ? 1 : 0);
    if (flip && i > 0) return "R11";
    if (m4 && i <= 1) return "R3";
    if (r == 0) return "R2";
    if (r <= 2) return "R4";
    if (r < 4 + MLEN) return "R5";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!req_o && !done_o && !err_o, "R9", {req_o, done_o, err_o}, 0);
  endtask

  // abort_at >= 0 leaves the sequence at that step without acknowledging
  task automatic run_seq(input bit m4, input bit flip, input bit do_start, input int abort_at);
    int n;
    int total;
    logic [9:0] e;
    mode4_i = m4;
    if (do_start) pulse_start();
    n = 0;
    while (!req_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    chk(n == POR, "R1", n, POR);
    total = (m4 ? 1 : 0) + 4 + MLEN + 3;
    for (int i = 0; i < total; i++) begin
      int d;
      e = exp_step(m4, i);
      chk(req_o && {nibble_o, rs_o, data_o} == e, tag_of(m4, i, flip),
          {req_o, nibble_o, rs_o, data_o}, {1'b1, e});
      if (flip && i == 0) mode4_i = ~m4;
      if (i == abort_at) return;
      d = $urandom % 4;
      for (int k = 0; k < d; k++) begin
        @(negedge clk_i);
        chk(req_o && {nibble_o, rs_o, data_o} == e, "R7",
            {req_o, nibble_o, rs_o, data_o}, {1'b1, e});
      end
      ack_i = 1'b1;
      @(negedge clk_i);
      ack_i = 1'b0;
    end
    chk(done_o && !req_o, "R8", {done_o, req_o}, 2'b10);
    repeat (3) @(negedge clk_i);
    chk(done_o && !req_o, "R8", {done_o, req_o}, 2'b10);
    mode4_i = m4;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk_i);
    chk(!req_o && !done_o && !err_o, "R1", {req_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    // sequence runs by itself after reset, 8-bit
    run_seq(1'b0, 1'b0, 1'b0, -1);
    run_seq(1'b1, 1'b0, 1'b1, -1);
    // stray acknowledge after completion
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    chk(err_o && done_o && !req_o, "R10", {err_o, done_o, req_o}, 3'b110);
    @(negedge clk_i);
    chk(err_o, "R10", err_o, 1);
    // restart mid-sequence, then a full run
    run_seq(1'b1, 1'b0, 1'b1, 4);
    run_seq(1'b0, 1'b0, 1'b1, 2);
    run_seq(1'b1, 1'b0, 1'b1, -1);
    // width select flipped after the wait
    run_seq(1'b1, 1'b1, 1'b1, -1);
    run_seq(1'b0, 1'b1, 1'b1, -1);
    for (int t = 0; t < 4; t++) run_seq(1'($urandom % 2), 1'b0, 1'b1, -1);
    summary();
  end
endmodule